// File: doc/BRIEF.md
# ECC Error Capture and Status Register

This block sits on a memory read path, downstream of a single-error-correct, double-error-detect checker. Every checked read arrives as a one-cycle valid strobe, together with a correctable flag, an uncorrectable flag, the physical address and the syndrome. The first error seen is frozen into one 32-bit status word, which software reads and clears through a plain register port. Every later error is dropped from the status word until software has released it.

Separate enables route a held correctable error to a non-maskable interrupt request and a held uncorrectable error to a system error line. Hardware scrubbing of corrected data is on by default. When it is on, each corrected read raises a one-cycle writeback request that carries the address of that read, whether or not the status slot is free. The scrub write itself and the ECC logic sit outside this block.

Top module: `ecc_err_logger`

## Requirements
- R1: A read with valid=1, ce=1 and ue=0 that finds both status flags clear sets bit 0 on the next clock and leaves bit 1 clear. The same edge loads address bits [31:13] into bits 30:12 and the syndrome into bits 11:4.
- R2: A read with valid=1 and ue=1 that finds the slot free sets bit 1 only, whatever ce is, and captures address and syndrome as in R1.
- R3: While bit 0 or bit 1 is set, further errors change no bit of the status word. At most one of the two flags is ever set.
- R4: A register write with data bit 0 or bit 1 at 1 clears the matching flag. A 0 in those positions leaves the flags untouched. Once the flags are clear, the next error is captured.
- R5: Register writes load bit 31 (scrub disable), bit 3 (system error enable) and bit 2 (interrupt enable), which read back as written. Written data in bits 30:4 has no effect.
- R6: A read with valid=1, ce=1 and ue=0 while bit 31 is 0 gives scrub_req=1 for exactly the next cycle, with scrub_addr equal to that read's address. No request follows when bit 31 is 1 or when ue=1.
- R7: nmi_req is high exactly while bit 0 and bit 2 are both set.
- R8: serr_out is high exactly while bit 1 and bit 3 are both set.
- R9: After reset the status word is 0 (scrubbing enabled, both enables off) and no output is asserted.
- R10: Error flags presented with valid=0 are ignored. They neither capture nor scrub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A checked read is presented this cycle |
| chk_ce | input | 1 | Read had a corrected single-bit error |
| chk_ue | input | 1 | Read had an uncorrectable error |
| chk_addr | input | ADDR_W | Physical address of the read |
| chk_syn | input | SYN_W | Syndrome of the read |
| reg_wr_en | input | 1 | Write strobe for the status word |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Current status word |
| nmi_req | output | 1 | Interrupt request level for a held correctable error |
| serr_out | output | 1 | System error level for a held uncorrectable error |
| scrub_req | output | 1 | One-cycle scrub writeback request |
| scrub_addr | output | ADDR_W | Address to scrub, valid with scrub_req |

## Verification
The bench uses the default parameters: a 32-bit address, an 8-bit syndrome and a 19-bit captured address field. With these values the status word is exactly 32 bits wide, and the control bits sit at the fixed positions 31, 3 and 2. Random addresses therefore exercise every captured address bit and every syndrome bit. The random mix also covers errors that arrive while the slot is held, clears that land in the same cycle as a new error, and scrub toggling. The directed cases cover simultaneous ce and ue, and clear writes that name the wrong flag.

// File: rtl/ecc_err_logger.sv
module ecc_err_logger #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int CAP_W  = 19
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           chk_valid,
  input  logic                           chk_ce,
  input  logic                           chk_ue,
  input  logic [ADDR_W-1:0]              chk_addr,
  input  logic [SYN_W-1:0]               chk_syn,
  input  logic                           reg_wr_en,
  input  logic [CAP_W+SYN_W+4:0]         reg_wdata,
  output logic [CAP_W+SYN_W+4:0]         reg_rdata,
  output logic                           nmi_req,
  output logic                           serr_out,
  output logic                           scrub_req,
  output logic [ADDR_W-1:0]              scrub_addr
);
  localparam int REG_W  = CAP_W + SYN_W + 5;
  localparam int CAP_LO = ADDR_W - CAP_W;

  logic              scrub_off, nmi_en, serr_en, ce_flag, ue_flag;
  logic [CAP_W-1:0]  cap_addr;
  logic [SYN_W-1:0]  cap_syn;

  wire slot_free = !ce_flag && !ue_flag;
  wire take      = slot_free && chk_valid && (chk_ce || chk_ue);
  wire fix_hit   = chk_valid && chk_ce && !chk_ue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_off  <= 1'b0;
      nmi_en     <= 1'b0;
      serr_en    <= 1'b0;
      ce_flag    <= 1'b0;
      ue_flag    <= 1'b0;
      cap_addr   <= '0;
      cap_syn    <= '0;
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
    end else begin
      if (reg_wr_en) begin
        scrub_off <= reg_wdata[REG_W-1];
        serr_en   <= reg_wdata[3];
        nmi_en    <= reg_wdata[2];
      end
      if (take) begin
        ce_flag  <= !chk_ue;
        ue_flag  <= chk_ue;
        cap_addr <= chk_addr[ADDR_W-1:CAP_LO];
        cap_syn  <= chk_syn;
      end else if (reg_wr_en) begin
        if (reg_wdata[0]) ce_flag <= 1'b0;
        if (reg_wdata[1]) ue_flag <= 1'b0;
      end
      scrub_req <= fix_hit && !scrub_off;
      if (fix_hit && !scrub_off) scrub_addr <= chk_addr;
    end
  end

  assign reg_rdata = {scrub_off, cap_addr, cap_syn, serr_en, nmi_en, ue_flag, ce_flag};
  assign nmi_req   = ce_flag && nmi_en;
  assign serr_out  = ue_flag && serr_en;

  AST_CE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] == 2'b00 && chk_valid && chk_ce && !chk_ue) |=> (reg_rdata[1:0] == 2'b01)); // R1
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] != 2'b00) |=> $stable(reg_rdata[REG_W-2:4])); // R3
  AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_rdata[1:0]) <= 1); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !(reg_wr_en && reg_wdata[0])) |=> reg_rdata[0]); // R4
  AST_SCRUB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> $past(chk_valid && chk_ce && !chk_ue && !reg_rdata[REG_W-1])); // R6
endmodule

// File: tb/ecc_err_logger_tb_top.sv
module ecc_err_logger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, SYN_W = 8, CAP_W = 19;
  localparam int REG_W = CAP_W + SYN_W + 5;

  logic clk = 0, rst_n = 0;
  logic chk_valid = 0, chk_ce = 0, chk_ue = 0, reg_wr_en = 0;
  logic [ADDR_W-1:0] chk_addr = '0;
  logic [SYN_W-1:0]  chk_syn = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic nmi_req, serr_out, scrub_req;
  logic [ADDR_W-1:0] scrub_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic m_off, m_nmi, m_serr, m_ce, m_ue, m_srq;
  logic [CAP_W-1:0] m_addr;
  logic [SYN_W-1:0] m_syn;
  logic [ADDR_W-1:0] m_sad;

  ecc_err_logger #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .CAP_W(CAP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_ce(chk_ce), .chk_ue(chk_ue),
    .chk_addr(chk_addr), .chk_syn(chk_syn), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_req(nmi_req), .serr_out(serr_out),
    .scrub_req(scrub_req), .scrub_addr(scrub_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [REG_W-1:0] exp_word();
    return {m_off, m_addr, m_syn, m_serr, m_nmi, m_ue, m_ce};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_off, m_nmi, m_serr, m_ce, m_ue, m_srq} = '0;
    m_addr = '0; m_syn = '0; m_sad = '0;
  endtask

  task automatic model_step();
    logic free, fix;
    free = !m_ce && !m_ue;
    fix = chk_valid && chk_ce && !chk_ue;
    m_srq = fix && !m_off;
    if (m_srq) m_sad = chk_addr;
    if (free && chk_valid && (chk_ce || chk_ue)) begin
      m_ue = chk_ue; m_ce = !chk_ue;
      m_addr = chk_addr[ADDR_W-1:ADDR_W-CAP_W]; m_syn = chk_syn;
    end else if (reg_wr_en) begin
      if (reg_wdata[0]) m_ce = 0;
      if (reg_wdata[1]) m_ue = 0;
    end
    if (reg_wr_en) begin
      m_off = reg_wdata[REG_W-1]; m_serr = reg_wdata[3]; m_nmi = reg_wdata[2];
    end
  endtask

  task automatic cyc(logic v, logic ce, logic ue, logic [ADDR_W-1:0] a, logic [SYN_W-1:0] s,
                     logic we, logic [REG_W-1:0] wd);
    @(negedge clk);
    chk_valid = v; chk_ce = ce; chk_ue = ue; chk_addr = a; chk_syn = s;
    reg_wr_en = we; reg_wdata = wd;
    @(posedge clk);
    #1;
    model_step();
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, '0, 0, '0);
  endtask

  task automatic check_all(string req);
    chk(req, reg_rdata, exp_word());
    chk(req, nmi_req, m_ce && m_nmi);
    chk(req, serr_out, m_ue && m_serr);
    chk(req, scrub_req, m_srq);
    if (m_srq) chk(req, scrub_addr, m_sad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] held;
    process::self().srandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R9", reg_rdata, '0);
    chk("R9", {nmi_req, serr_out, scrub_req}, 3'b000);

    cyc(0, 0, 0, '0, '0, 1, 32'h7FFF_FFFC);
    chk("R5", reg_rdata, 32'h0000_000C);

    cyc(1, 1, 0, 32'hABCD_E123, 8'h5A, 0, '0);
    chk("R1", reg_rdata, {1'b0, 19'h55E6F, 8'h5A, 4'b1101});
    chk("R7", nmi_req, 1);
    chk("R6", {scrub_req, scrub_addr}, {1'b1, 32'hABCD_E123});
    idle();
    chk("R6", scrub_req, 0);

    held = reg_rdata;
    cyc(1, 0, 1, 32'h1234_5678, 8'hC3, 0, '0);
    chk("R3", reg_rdata, held);
    chk("R8", serr_out, 0);
    cyc(1, 1, 0, 32'h0F0F_0000, 8'h11, 0, '0);
    chk("R3", reg_rdata, held);
    chk("R6", {scrub_req, scrub_addr}, {1'b1, 32'h0F0F_0000});

    cyc(0, 0, 0, '0, '0, 1, 32'h0000_000E);
    chk("R4", reg_rdata[0], 1);
    cyc(0, 0, 0, '0, '0, 1, 32'h0000_000C);
    chk("R4", reg_rdata[0], 1);
    cyc(0, 0, 0, '0, '0, 1, 32'h0000_000D);
    chk("R4", reg_rdata[1:0], 2'b00);
    chk("R7", nmi_req, 0);

    cyc(0, 1, 1, 32'hFFFF_FFFF, 8'hFF, 0, '0);
    chk("R10", reg_rdata, 32'h0000_000C | (held & 32'h7FFF_FFF0));
    chk("R10", scrub_req, 0);

    cyc(1, 0, 1, 32'h8000_2000, 8'h3C, 0, '0);
    chk("R2", reg_rdata[1:0], 2'b10);
    chk("R8", serr_out, 1);
    chk("R6", scrub_req, 0);
    cyc(0, 0, 0, '0, '0, 1, 32'h0000_000E);
    chk("R8", serr_out, 0);

    cyc(1, 1, 1, 32'h4444_6000, 8'h99, 0, '0);
    chk("R2", reg_rdata, {1'b0, 19'h22223, 8'h99, 4'b1110});
    chk("R6", scrub_req, 0);
    cyc(0, 0, 0, '0, '0, 1, 32'h8000_000E);
    chk("R5", reg_rdata[31], 1);
    cyc(1, 1, 0, 32'h0000_4000, 8'h01, 0, '0);
    chk("R6", scrub_req, 0);
    chk("R4", reg_rdata[1:0], 2'b01);
    check_all("R1");

    for (int i = 0; i < 4000; i++) begin
      logic v, ce, ue, we;
      logic [REG_W-1:0] wd;
      v  = ($urandom_range(0, 3) != 0);
      ce = $urandom_range(0, 1);
      ue = ($urandom_range(0, 4) == 0);
      we = ($urandom_range(0, 5) == 0);
      wd = $urandom;
      cyc(v, ce, ue, $urandom, $urandom, we, wd);
      check_all("R3");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule